// File: doc/BRIEF.md
# Hierarchical Delay Setting Stepper

This block holds the delay setting of one data lane and moves it by one position up or down when asked. A setting is a mixed-radix number with four digits, from most to least significant: a coarse digit (0..1), a clock-delay digit (0..2), a tap digit (0..tap ceiling) and a fine-phase digit (0..6). The tap ceiling depends on the selected memory-clock grade. The carry from clock delay into coarse is unusual. When coarse goes up, clock delay goes down by one. When coarse goes down, clock delay goes up by one.

Each time the setting changes, the block recomputes two delay-bank control bits, an enable and a select. They come from where the tap and phase digits fall relative to grade-dependent thresholds. A training sequencer loads a starting setting, then pulses the step strobes and watches the done and error outputs. All pins are plain control and status pins. The block has no streaming interface, so it has no valid/ready handshake and no back-pressure.

Top module: `dly_stepper`

## Requirements
- R1: Reset state: all four digits are 0, bank enable and bank select are 1, and done and error are 0.
- R2: Load: when `ld_valid` is high at a clock edge, the digits take the `ld_*` values after that edge. The bank bits are recomputed for the grade in force, done and error stay 0, and any step strobe in the same cycle is ignored.
- R3: Increment, tried in this order:
  - If phase < 6, phase+1.
  - Else if tap < ceiling, phase=0 and tap+1.
  - Else if clock delay < 2, phase=0, tap=0 and clock delay+1.
  - Else if coarse < 1, phase=0, tap=0, clock delay-1 and coarse+1.
  - Otherwise the step fails.
- R4: Decrement, tried in this order:
  - If phase > 0, phase-1.
  - Else if tap > 0, phase=6 and tap-1.
  - Else if clock delay > 0, phase=6, tap=ceiling and clock delay-1.
  - Else if coarse > 0, phase=6, tap=ceiling, clock delay+1 and coarse-1.
  - Otherwise the step fails.
- R5: `speed_sel` encoding and tap ceiling: 0 is the 800 grade (ceiling 12), 1 is the 1066 grade (ceiling 10), 2 is the 1333 grade (ceiling 13), and 3 behaves as code 0.
- R6: The bank bits are computed from thresholds (low tap, high tap, low phase, high phase). These are (3,10,2,3) for grade 0, (2,8,6,7) for grade 1 and (3,11,6,4) for grade 2.
  - If tap < low tap, or tap = low tap and phase < low phase: enable=1, select=1.
  - Else if tap < high tap, or tap = high tap and phase < high phase: enable=0, select=0.
  - Otherwise: enable=1, select=0.
- R7: A step that fails raises error for one cycle, raises no done, and leaves the digits and the bank bits unchanged.
- R8: Increment and decrement strobed together, without a load, are ignored and raise error for one cycle.
- R9: A successful step shows its new digits and bank bits, together with a one-cycle done pulse, in the cycle after the strobe edge.
- R10: With no load and no strobe, the digits and the bank bits hold, and done and error are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| speed_sel | input | 2 | Memory-clock grade code |
| ld_valid | input | 1 | Load the `ld_*` digits |
| ld_crs | input | 1 | Coarse digit to load |
| ld_cdl | input | 2 | Clock-delay digit to load |
| ld_tap | input | 4 | Tap digit to load |
| ld_ph | input | 3 | Phase digit to load |
| inc_req | input | 1 | Step up strobe |
| dec_req | input | 1 | Step down strobe |
| crs_o | output | 1 | Current coarse digit |
| cdl_o | output | 2 | Current clock-delay digit |
| tap_o | output | 4 | Current tap digit |
| ph_o | output | 3 | Current phase digit |
| bank_en_o | output | 1 | Delay-bank enable |
| bank_sel_o | output | 1 | Delay-bank select |
| done_o | output | 1 | One-cycle pulse after a successful step |
| err_o | output | 1 | One-cycle pulse after a refused step |

## Verification
Every result is due exactly one cycle after the edge that captures the request. This holds for the loaded digits and their bank bits, the stepped digits, done and error. The bench drives each request on a falling edge, lets one rising edge pass, and samples on the following falling edge. That sample point lies one register stage after the strobe and before the next request. For every grade code, the sweep loads each legal setting and checks the load result, then applies one increment or one decrement and checks the step result. Separate checks look at idle cycles right after a step, to confirm that done drops and the state holds.

// File: rtl/dly_step_pkg.sv
package dly_step_pkg;
  localparam int CRS_W = 1;
  localparam int CDL_W = 2;
  localparam int TAP_W = 4;
  localparam int PH_W  = 3;

  localparam logic [CRS_W-1:0] CRS_TOP = CRS_W'(1);
  localparam logic [CDL_W-1:0] CDL_TOP = CDL_W'(2);
  localparam logic [PH_W-1:0]  PH_TOP  = PH_W'(6);

  typedef struct packed {
    logic [CRS_W-1:0] crs;
    logic [CDL_W-1:0] cdl;
    logic [TAP_W-1:0] tap;
    logic [PH_W-1:0]  ph;
  } dly_set_t;

  typedef struct packed {
    logic [TAP_W-1:0] tap_lo;
    logic [TAP_W-1:0] tap_hi;
    logic [PH_W-1:0]  ph_lo;
    logic [PH_W-1:0]  ph_hi;
  } bank_thr_t;
endpackage

// File: rtl/dly_speed_cfg.sv
module dly_speed_cfg
  import dly_step_pkg::*;
#(
  parameter int TAP_CEIL_G0 = 12,
  parameter int TAP_CEIL_G1 = 10,
  parameter int TAP_CEIL_G2 = 13,
  parameter logic [4*TAP_W-1:0] THR_TAP_G0 = {TAP_W'(3), TAP_W'(10), TAP_W'(0), TAP_W'(0)},
  parameter logic [4*TAP_W-1:0] THR_TAP_G1 = {TAP_W'(2), TAP_W'(8),  TAP_W'(0), TAP_W'(0)},
  parameter logic [4*TAP_W-1:0] THR_TAP_G2 = {TAP_W'(3), TAP_W'(11), TAP_W'(0), TAP_W'(0)},
  parameter logic [2*PH_W-1:0]  THR_PH_G0  = {PH_W'(2), PH_W'(3)},
  parameter logic [2*PH_W-1:0]  THR_PH_G1  = {PH_W'(6), PH_W'(7)},
  parameter logic [2*PH_W-1:0]  THR_PH_G2  = {PH_W'(6), PH_W'(4)}
) (
  input  logic [1:0]       speed_sel,
  output logic [TAP_W-1:0] tap_ceil,
  output bank_thr_t        thr
);
  localparam int HI = 4*TAP_W;

  always_comb begin
    unique case (speed_sel)
      2'd1: begin
        tap_ceil   = TAP_W'(TAP_CEIL_G1);
        thr.tap_lo = THR_TAP_G1[HI-1 -: TAP_W];
        thr.tap_hi = THR_TAP_G1[HI-TAP_W-1 -: TAP_W];
        thr.ph_lo  = THR_PH_G1[2*PH_W-1 -: PH_W];
        thr.ph_hi  = THR_PH_G1[PH_W-1:0];
      end
      2'd2: begin
        tap_ceil   = TAP_W'(TAP_CEIL_G2);
        thr.tap_lo = THR_TAP_G2[HI-1 -: TAP_W];
        thr.tap_hi = THR_TAP_G2[HI-TAP_W-1 -: TAP_W];
        thr.ph_lo  = THR_PH_G2[2*PH_W-1 -: PH_W];
        thr.ph_hi  = THR_PH_G2[PH_W-1:0];
      end
      default: begin
        tap_ceil   = TAP_W'(TAP_CEIL_G0);
        thr.tap_lo = THR_TAP_G0[HI-1 -: TAP_W];
        thr.tap_hi = THR_TAP_G0[HI-TAP_W-1 -: TAP_W];
        thr.ph_lo  = THR_PH_G0[2*PH_W-1 -: PH_W];
        thr.ph_hi  = THR_PH_G0[PH_W-1:0];
      end
    endcase
  end
endmodule

// File: rtl/dly_step_next.sv
module dly_step_next
  import dly_step_pkg::*;
#(
  parameter bit UP = 1'b1
) (
  input  dly_set_t         cur,
  input  logic [TAP_W-1:0] tap_ceil,
  output dly_set_t         nxt,
  output logic             ok
);
  generate
    if (UP) begin : g_up
      always_comb begin
        nxt = cur;
        ok  = 1'b1;
        if (cur.ph < PH_TOP) begin
          nxt.ph = cur.ph + 1'b1;
        end else if (cur.tap < tap_ceil) begin
          nxt.ph  = '0;
          nxt.tap = cur.tap + 1'b1;
        end else if (cur.cdl < CDL_TOP) begin
          nxt.ph  = '0;
          nxt.tap = '0;
          nxt.cdl = cur.cdl + 1'b1;
        end else if (cur.crs < CRS_TOP) begin
          nxt.ph  = '0;
          nxt.tap = '0;
          nxt.cdl = cur.cdl - 1'b1;
          nxt.crs = cur.crs + 1'b1;
        end else begin
          ok = 1'b0;
        end
      end
    end else begin : g_dn
      always_comb begin
        nxt = cur;
        ok  = 1'b1;
        if (cur.ph != '0) begin
          nxt.ph = cur.ph - 1'b1;
        end else if (cur.tap != '0) begin
          nxt.ph  = PH_TOP;
          nxt.tap = cur.tap - 1'b1;
        end else if (cur.cdl != '0) begin
          nxt.ph  = PH_TOP;
          nxt.tap = tap_ceil;
          nxt.cdl = cur.cdl - 1'b1;
        end else if (cur.crs != '0) begin
          nxt.ph  = PH_TOP;
          nxt.tap = tap_ceil;
          nxt.cdl = cur.cdl + 1'b1;
          nxt.crs = cur.crs - 1'b1;
        end else begin
          ok = 1'b0;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/dly_bank_calc.sv
module dly_bank_calc
  import dly_step_pkg::*;
(
  input  dly_set_t  set,
  input  bank_thr_t thr,
  output logic      bank_en,
  output logic      bank_sel
);
  logic below_lo, below_hi;

  always_comb begin
    below_lo = (set.tap < thr.tap_lo) || ((set.tap == thr.tap_lo) && (set.ph < thr.ph_lo));
    below_hi = (set.tap < thr.tap_hi) || ((set.tap == thr.tap_hi) && (set.ph < thr.ph_hi));
    bank_sel = below_lo;
    bank_en  = below_lo || !below_hi;
  end
endmodule

// File: rtl/dly_stepper.sv
module dly_stepper
  import dly_step_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       speed_sel,
  input  logic             ld_valid,
  input  logic [CRS_W-1:0] ld_crs,
  input  logic [CDL_W-1:0] ld_cdl,
  input  logic [TAP_W-1:0] ld_tap,
  input  logic [PH_W-1:0]  ld_ph,
  input  logic             inc_req,
  input  logic             dec_req,
  output logic [CRS_W-1:0] crs_o,
  output logic [CDL_W-1:0] cdl_o,
  output logic [TAP_W-1:0] tap_o,
  output logic [PH_W-1:0]  ph_o,
  output logic             bank_en_o,
  output logic             bank_sel_o,
  output logic             done_o,
  output logic             err_o
);
  dly_set_t         cur_q, cand;
  dly_set_t         nxt [2];
  logic             ok  [2];
  logic [TAP_W-1:0] tap_ceil;
  bank_thr_t        thr;
  logic             en_c, sel_c, en_q, sel_q;
  logic             one_dir, step_ok, upd, fail;

  dly_speed_cfg u_cfg (
    .speed_sel (speed_sel),
    .tap_ceil  (tap_ceil),
    .thr       (thr)
  );

  for (genvar d = 0; d < 2; d++) begin : g_dir
    dly_step_next #(.UP(d == 0)) u_next (
      .cur      (cur_q),
      .tap_ceil (tap_ceil),
      .nxt      (nxt[d]),
      .ok       (ok[d])
    );
  end

  always_comb begin
    one_dir = inc_req ^ dec_req;
    step_ok = inc_req ? ok[0] : ok[1];
    if (ld_valid) cand = '{crs: ld_crs, cdl: ld_cdl, tap: ld_tap, ph: ld_ph};
    else          cand = inc_req ? nxt[0] : nxt[1];
    upd  = ld_valid || (one_dir && step_ok);
    fail = !ld_valid && ((inc_req && dec_req) || (one_dir && !step_ok));
  end

  dly_bank_calc u_bank (
    .set      (cand),
    .thr      (thr),
    .bank_en  (en_c),
    .bank_sel (sel_c)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= '0;
      en_q   <= 1'b1;
      sel_q  <= 1'b1;
      done_o <= 1'b0;
      err_o  <= 1'b0;
    end else begin
      if (upd) begin
        cur_q <= cand;
        en_q  <= en_c;
        sel_q <= sel_c;
      end
      done_o <= !ld_valid && one_dir && step_ok;
      err_o  <= fail;
    end
  end

  assign crs_o      = cur_q.crs;
  assign cdl_o      = cur_q.cdl;
  assign tap_o      = cur_q.tap;
  assign ph_o       = cur_q.ph;
  assign bank_en_o  = en_q;
  assign bank_sel_o = sel_q;

  a_r8_both_err: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_req && dec_req && !ld_valid) |=> (err_o && !done_o && $stable(cur_q) && $stable(en_q)));

  a_r7_fail_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (one_dir && !ld_valid && !step_ok) |=> (err_o && !done_o && $stable(cur_q) && $stable(sel_q)));

  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc_req && !dec_req && !ld_valid) |=> (!done_o && !err_o && $stable(cur_q) && $stable(en_q) && $stable(sel_q)));

  a_r9_done_change: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !err_o && (cur_q != $past(cur_q)));

  a_r6_bank_legal: assert property (@(posedge clk) disable iff (!rst_n)
    !(bank_sel_o && !bank_en_o));

  a_r3_digit_range: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(ld_valid)) |-> (ph_o <= PH_TOP) && (cdl_o <= CDL_TOP));
endmodule

// File: tb/tb_dly_stepper.sv
module tb_dly_stepper;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] speed_sel = 2'd0;
  logic       ld_valid = 1'b0;
  logic       ld_crs = 1'b0;
  logic [1:0] ld_cdl = '0;
  logic [3:0] ld_tap = '0;
  logic [2:0] ld_ph = '0;
  logic       inc_req = 1'b0, dec_req = 1'b0;
  logic       crs_o;
  logic [1:0] cdl_o;
  logic [3:0] tap_o;
  logic [2:0] ph_o;
  logic       bank_en_o, bank_sel_o, done_o, err_o;

  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  dly_stepper dut (
    .clk(clk), .rst_n(rst_n), .speed_sel(speed_sel), .ld_valid(ld_valid),
    .ld_crs(ld_crs), .ld_cdl(ld_cdl), .ld_tap(ld_tap), .ld_ph(ld_ph),
    .inc_req(inc_req), .dec_req(dec_req), .crs_o(crs_o), .cdl_o(cdl_o),
    .tap_o(tap_o), .ph_o(ph_o), .bank_en_o(bank_en_o), .bank_sel_o(bank_sel_o),
    .done_o(done_o), .err_o(err_o)
  );

  function automatic int ceil_of(int s);
    return (s == 1) ? 10 : (s == 2) ? 13 : 12;
  endfunction

  // R6 thresholds per grade, code 3 as code 0 (R5)
  function automatic void bank_of(int s, int t, int p, output bit en, output bit sel);
    int t0, t1, p0, p1;
    bit lo, hi;
    case (s)
      1: begin t0 = 2; t1 = 8;  p0 = 6; p1 = 7; end
      2: begin t0 = 3; t1 = 11; p0 = 6; p1 = 4; end
      default: begin t0 = 3; t1 = 10; p0 = 2; p1 = 3; end
    endcase
    lo  = (t < t0) || (t == t0 && p < p0);
    hi  = (t < t1) || (t == t1 && p < p1);
    sel = lo;
    en  = lo || !hi;
  endfunction

  function automatic bit step_of(int s, bit up, inout int c, inout int k, inout int t, inout int p);
    int tm = ceil_of(s);
    if (up) begin
      if (p < 6) p++;
      else if (t < tm) begin p = 0; t++; end
      else if (k < 2) begin p = 0; t = 0; k++; end
      else if (c < 1) begin p = 0; t = 0; k--; c++; end
      else return 0;
    end else begin
      if (p > 0) p--;
      else if (t > 0) begin p = 6; t--; end
      else if (k > 0) begin p = 6; t = tm; k--; end
      else if (c > 0) begin p = 6; t = tm; k++; c--; end
      else return 0;
    end
    return 1;
  endfunction

  function automatic logic [13:0] pack(int c, int k, int t, int p, bit en, bit sel, bit dn, bit er);
    return {c[0], k[1:0], t[3:0], p[2:0], en, sel, dn, er};
  endfunction

  function automatic logic [13:0] seen();
    return {crs_o, cdl_o, tap_o, ph_o, bank_en_o, bank_sel_o, done_o, err_o};
  endfunction

  task automatic chk(input string req, input logic [13:0] act, input logic [13:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%b exp=%b", req, act, exp);
    end
  endtask

  task automatic load_case(int s, int c, int k, int t, int p);
    bit en, sel;
    @(negedge clk);
    speed_sel = 2'(s);
    ld_valid = 1'b1; ld_crs = c[0]; ld_cdl = 2'(k); ld_tap = 4'(t); ld_ph = 3'(p);
    @(negedge clk);
    ld_valid = 1'b0;
    bank_of(s, t, p, en, sel);
    chk("R2 R6 load", seen(), pack(c, k, t, p, en, sel, 0, 0));
  endtask

  task automatic step_case(int s, int c, int k, int t, int p, bit up);
    bit en0, sel0, en, sel, ok;
    int c1 = c, k1 = k, t1 = t, p1 = p;
    load_case(s, c, k, t, p);
    bank_of(s, t, p, en0, sel0);
    inc_req = up; dec_req = !up;
    @(negedge clk);
    inc_req = 0; dec_req = 0;
    ok = step_of(s, up, c1, k1, t1, p1);
    if (ok) begin
      bank_of(s, t1, p1, en, sel);
      chk(up ? "R3 R5 R6 R9 inc" : "R4 R5 R6 R9 dec", seen(), pack(c1, k1, t1, p1, en, sel, 1, 0));
    end else begin
      chk("R7 limit", seen(), pack(c, k, t, p, en0, sel0, 0, 1));
    end
  endtask

  initial begin
    bit en, sel;
    @(negedge clk);
    chk("R1 reset", seen(), pack(0, 0, 0, 0, 1, 1, 0, 0));
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", seen(), pack(0, 0, 0, 0, 1, 1, 0, 0));

    for (int s = 0; s < 4; s++)
      for (int c = 0; c < 2; c++)
        for (int k = 0; k < 3; k++)
          for (int t = 0; t <= ceil_of(s); t++)
            for (int p = 0; p < 7; p++)
              for (int d = 0; d < 2; d++)
                step_case(s, c, k, t, p, d == 0);

    // R8: both strobes together
    load_case(1, 0, 1, 5, 3);
    inc_req = 1; dec_req = 1;
    @(negedge clk);
    inc_req = 0; dec_req = 0;
    bank_of(1, 5, 3, en, sel);
    chk("R8 both strobes", seen(), pack(0, 1, 5, 3, en, sel, 0, 1));

    // R2: load wins over a strobe in the same cycle
    @(negedge clk);
    speed_sel = 2'd2;
    ld_valid = 1; ld_crs = 1; ld_cdl = 2; ld_tap = 4'd13; ld_ph = 3'd6; inc_req = 1;
    @(negedge clk);
    ld_valid = 0; inc_req = 0;
    bank_of(2, 13, 6, en, sel);
    chk("R2 load beats strobe", seen(), pack(1, 2, 13, 6, en, sel, 0, 0));

    // R9/R10: done lasts one cycle, state holds while idle
    load_case(0, 0, 0, 3, 1);
    dec_req = 1;
    @(negedge clk);
    dec_req = 0;
    bank_of(0, 3, 0, en, sel);
    chk("R9 done", seen(), pack(0, 0, 3, 0, en, sel, 1, 0));
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R10 idle hold", seen(), pack(0, 0, 3, 0, en, sel, 0, 0));
    end

    // R10: a grade change alone moves nothing
    speed_sel = 2'd1;
    @(negedge clk);
    chk("R10 grade change idle", seen(), pack(0, 0, 3, 0, en, sel, 0, 0));

    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog act=running exp=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule